// File: doc/BRIEF.md
# Cable Diagnostic Fault Classifier

This block sits behind a time-domain cable test on a single twisted pair. Software writes a control register to launch a measurement. The block sends a one-cycle launch pulse to the measurement engine and waits for the engine to report completion. The engine then presents two echo peaks, one positive and one negative. Each peak comes with an amplitude and a packed arrival-time word, and the engine also supplies a signed gain index.

The classifier unpacks each arrival-time word into a single count of phases. It compares the two arrival times against a bounded separation window and checks them against a fixed hybrid reference time. It gates any fault on a noise floor and on the sign of the gain index. It then registers a two-bit verdict: good, open, or short within the pair.

The verdict stays readable until the next launch. Software ends a test by writing zero to the control register. The measurement engine is outside this block, and a testbench drives its outputs directly.

Top module: `cable_diag_classifier`

## Requirements
- R1: After reset the control register reads 0, `resultValid` is 0 and `resultCode` is 0 (good).
- R2: In the control register, bit 0 is the running flag and bit 1 is the completion flag. A write with bit 0 set, made while the register reads 0, sets the running flag and clears the completion flag. It also drives `measStart` high for exactly one cycle, starting on the clock edge that takes the write.
- R3: While the running flag is set, a write with bit 0 set is ignored: it raises no launch pulse and leaves the control register and the result unchanged.
- R4: When `measDone` is high while the running flag is set and the completion flag is clear, the completion flag is set on that clock edge. When the running flag is clear, `measDone` is ignored.
- R5: Each arrival-time word carries a cycle count in bits 13:7 and a phase in bits 6:0. The arrival time in phases is the cycle count times 96 plus the phase. All 128 phase values are accepted.
- R6: The separation between the two arrival times is computed as a signed value. A peak pair counts as a valid reflection only when the later peak trails the earlier one by at least 96 phases and by fewer than 185 phases. Equal times, or a separation outside that range, give code 0.
- R7: When the negative peak is the later one and the pair is a valid reflection, the raw verdict is code 1 (open).
- R8: When the positive peak is the later one and the pair is a valid reflection, the raw verdict is code 2 (short).
- R9: A raw verdict of open or short is reported only when both amplitudes are strictly greater than 20 and the gain index is zero or positive. Otherwise the reported code is 0 (good). Code 3 is reserved for an unspecified diagnostic error.
- R10: `resultValid` goes high for one cycle, one clock edge after the completion flag is set, and `resultCode` takes the verdict on that same edge. `resultCode` then holds until the next accepted launch, which resets it to 0.
- R11: Any write with bit 0 clear stops the test. It clears both flags on that edge and leaves `resultCode` unchanged. If the stop arrives before the verdict is registered, no `resultValid` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 2 | Control write data; bit 0 is start/run |
| ctlRdData | output | 2 | Control register: bit 1 is completion, bit 0 is running |
| measStart | output | 1 | One-cycle launch pulse to the measurement engine |
| measDone | input | 1 | Completion indication from the measurement engine |
| posAmp | input | 12 | Positive echo peak amplitude, unsigned |
| negAmp | input | 12 | Negative echo peak amplitude, unsigned |
| gainIdx | input | 8 | Gain index, two's complement |
| posTime | input | 14 | Packed arrival time of the positive peak |
| negTime | input | 14 | Packed arrival time of the negative peak |
| resultValid | output | 1 | One-cycle pulse when a new verdict is registered |
| resultCode | output | 2 | Verdict: 0 good, 1 open, 2 short, 3 unspecified |

## Verification
A stuck or skipped control state shows at the control register on the first sample after a write or after `measDone`. It can appear as a missing or doubled launch pulse, or as a completion flag seen without a run. A wrong verdict path shows on the single `resultValid` cycle, one edge after completion, as a code that differs from the window and noise-gate arithmetic. The separation boundaries (95, 96, 184 and 185 phases), the noise floor at 20 and 21, and a gain index of -1 and 0 are each driven so that an off-by-one error in a bound changes the code at once. Phase fields above 95 reveal a time word that is not unpacked correctly, and a code that drifts between tests shows up as a failed hold check.

// File: rtl/cdiag_pkg.sv
package cdiag_pkg;

  // Control register layout: bit 0 run/start, bit 1 completion
  localparam int CTL_W     = 2;
  localparam int CTL_RUN   = 0;
  localparam int CTL_DONE  = 1;

  typedef enum logic [1:0] {
    CABLE_OK     = 2'd0,
    CABLE_OPEN   = 2'd1,
    CABLE_SHORT  = 2'd2,
    CABLE_UNSPEC = 2'd3
  } cableStatusE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_EVAL,
    ST_DONE
  } ctlStateE;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // register a new verdict, pulse valid
    logic clear;     // launch accepted: reset verdict to good
  } dpStrobeT;

  function automatic cableStatusE mapDetect(input logic [1:0] raw);
    case (raw)
      2'd0:    return CABLE_OK;
      2'd1:    return CABLE_OPEN;
      2'd2:    return CABLE_SHORT;
      default: return CABLE_UNSPEC;
    endcase
  endfunction

endpackage

// File: rtl/cdiag_time_unpack.sv
module cdiag_time_unpack #(
  parameter int CYC_W          = 7,
  parameter int PH_W           = 7,
  parameter int PHASES_PER_CYC = 96,
  parameter int PHC_W          = 14,
  localparam int TW            = CYC_W + PH_W
) (
  input  logic [TW-1:0]    timeWord,
  output logic [PHC_W-1:0] phaseCount
);

  logic [CYC_W-1:0] cycleField;
  logic [PH_W-1:0]  phaseField;

  assign cycleField = timeWord[TW-1:PH_W];
  assign phaseField = timeWord[PH_W-1:0];

  always_comb begin
    phaseCount = PHC_W'(cycleField) * PHC_W'(PHASES_PER_CYC) + PHC_W'(phaseField);
  end

endmodule

// File: rtl/cdiag_ctrl.sv
module cdiag_ctrl
  import cdiag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             measDone,
  output logic [CTL_W-1:0] ctlRdData,
  output logic             measStart,
  output dpStrobeT         strobe
);

  ctlStateE stateQ, stateD;
  logic     startReq, stopReq, startOk;

  assign startReq = ctlWrEn &&  ctlWrData[CTL_RUN];
  assign stopReq  = ctlWrEn && !ctlWrData[CTL_RUN];
  assign startOk  = startReq && (stateQ == ST_IDLE);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (startOk)  stateD = ST_RUN;
      ST_RUN:  if (measDone) stateD = ST_EVAL;
      ST_EVAL: stateD = ST_DONE;
      ST_DONE: stateD = ST_DONE;
      default: stateD = ST_IDLE;
    endcase
    if (stopReq && stateQ != ST_IDLE) stateD = ST_IDLE;
  end

  always_comb begin
    strobe.clear   = startOk;
    strobe.capture = (stateQ == ST_EVAL) && !stopReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      measStart <= 1'b0;
    end else begin
      stateQ    <= stateD;
      measStart <= startOk;
    end
  end

  always_comb begin
    ctlRdData           = '0;
    ctlRdData[CTL_RUN]  = (stateQ != ST_IDLE);
    ctlRdData[CTL_DONE] = (stateQ == ST_EVAL) || (stateQ == ST_DONE);
  end

endmodule

// File: rtl/cdiag_datapath.sv
module cdiag_datapath
  import cdiag_pkg::*;
#(
  parameter int CYC_W          = 7,
  parameter int PH_W           = 7,
  parameter int PHASES_PER_CYC = 96,
  parameter int MIN_SEP        = 96,
  parameter int SEP_MARGIN     = 89,
  parameter int JITTER         = 30,
  parameter int HYBRID_REF     = 0,
  parameter int NOISE_FLOOR    = 20,
  parameter int AMP_W          = 12,
  parameter int GAIN_W         = 8,
  localparam int TW            = CYC_W + PH_W,
  localparam int MAX_PH        = ((2**CYC_W) - 1) * PHASES_PER_CYC + (2**PH_W) - 1,
  localparam int PHC_W         = $clog2(MAX_PH + 1),
  localparam int DW            = PHC_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [AMP_W-1:0]  posAmp,
  input  logic [AMP_W-1:0]  negAmp,
  input  logic [GAIN_W-1:0] gainIdx,
  input  logic [TW-1:0]     posTime,
  input  logic [TW-1:0]     negTime,
  output logic              resultValid,
  output cableStatusE       resultCode
);

  localparam logic signed [DW-1:0] SEP_LO  = DW'(MIN_SEP);
  localparam logic signed [DW-1:0] SEP_HI  = DW'(MIN_SEP + SEP_MARGIN);
  localparam logic signed [DW-1:0] HYB     = DW'(HYBRID_REF);
  localparam logic signed [DW-1:0] JIT     = DW'(JITTER);
  localparam logic [AMP_W-1:0]     AMP_MIN = AMP_W'(NOISE_FLOOR);

  // index 0: positive peak, index 1: negative peak
  logic [1:0][TW-1:0]    timeArr;
  logic [1:0][PHC_W-1:0] phaseArr;

  assign timeArr[0] = posTime;
  assign timeArr[1] = negTime;

  for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
    cdiag_time_unpack #(
      .CYC_W(CYC_W), .PH_W(PH_W),
      .PHASES_PER_CYC(PHASES_PER_CYC), .PHC_W(PHC_W)
    ) u_unpack (
      .timeWord  (timeArr[gi]),
      .phaseCount(phaseArr[gi])
    );
  end

  logic signed [DW-1:0] posPh, negPh, posLead, negLead;
  logic                 posLateOk, negLateOk, gateOk;
  logic [1:0]           rawDetect, gatedDetect;

  function automatic logic inWindow(input logic signed [DW-1:0] sep);
    return (sep >= SEP_LO) && (sep < SEP_HI);
  endfunction

  always_comb begin
    posPh   = $signed({2'b00, phaseArr[0]});
    negPh   = $signed({2'b00, phaseArr[1]});
    posLead = posPh - negPh;
    negLead = negPh - posPh;

    posLateOk = inWindow(posLead) && (HYB < posPh) && (HYB < negPh + JIT);
    negLateOk = inWindow(negLead) && (HYB < negPh) && (HYB < posPh + JIT);

    if (posPh > negPh && posLateOk)      rawDetect = 2'd2;
    else if (negPh > posPh && negLateOk) rawDetect = 2'd1;
    else                                 rawDetect = 2'd0;

    gateOk      = (posAmp > AMP_MIN) && (negAmp > AMP_MIN) && !gainIdx[GAIN_W-1];
    gatedDetect = gateOk ? rawDetect : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultCode  <= CABLE_OK;
    end else if (strobe.clear) begin
      resultValid <= 1'b0;
      resultCode  <= CABLE_OK;
    end else if (strobe.capture) begin
      resultValid <= 1'b1;
      resultCode  <= mapDetect(gatedDetect);
    end else begin
      resultValid <= 1'b0;
    end
  end

endmodule

// File: rtl/cable_diag_classifier.sv
module cable_diag_classifier
  import cdiag_pkg::*;
#(
  parameter int CYC_W          = 7,
  parameter int PH_W           = 7,
  parameter int PHASES_PER_CYC = 96,
  parameter int MIN_SEP        = 96,
  parameter int SEP_MARGIN     = 89,
  parameter int JITTER         = 30,
  parameter int HYBRID_REF     = 0,
  parameter int NOISE_FLOOR    = 20,
  parameter int AMP_W          = 12,
  parameter int GAIN_W         = 8,
  localparam int TW            = CYC_W + PH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [1:0]        ctlWrData,
  output logic [1:0]        ctlRdData,
  output logic              measStart,
  input  logic              measDone,
  input  logic [AMP_W-1:0]  posAmp,
  input  logic [AMP_W-1:0]  negAmp,
  input  logic [GAIN_W-1:0] gainIdx,
  input  logic [TW-1:0]     posTime,
  input  logic [TW-1:0]     negTime,
  output logic              resultValid,
  output logic [1:0]        resultCode
);

  dpStrobeT    strobe;
  cableStatusE codeInt;

  cdiag_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctlWrEn  (ctlWrEn),
    .ctlWrData(ctlWrData),
    .measDone (measDone),
    .ctlRdData(ctlRdData),
    .measStart(measStart),
    .strobe   (strobe)
  );

  cdiag_datapath #(
    .CYC_W(CYC_W), .PH_W(PH_W), .PHASES_PER_CYC(PHASES_PER_CYC),
    .MIN_SEP(MIN_SEP), .SEP_MARGIN(SEP_MARGIN), .JITTER(JITTER),
    .HYBRID_REF(HYBRID_REF), .NOISE_FLOOR(NOISE_FLOOR),
    .AMP_W(AMP_W), .GAIN_W(GAIN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .posAmp     (posAmp),
    .negAmp     (negAmp),
    .gainIdx    (gainIdx),
    .posTime    (posTime),
    .negTime    (negTime),
    .resultValid(resultValid),
    .resultCode (codeInt)
  );

  assign resultCode = codeInt;

endmodule

// File: rtl/cdiag_checker.sv
module cdiag_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ctlWrEn,
  input logic [1:0] ctlWrData,
  input logic [1:0] ctlRdData,
  input logic       measStart,
  input logic       resultValid,
  input logic [1:0] resultCode
);

  // R2: launch pulse lasts one cycle and coincides with the running flag
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    measStart |-> (ctlRdData[0] && !ctlRdData[1]) ##1 !measStart);

  // R3: start while running raises no launch pulse
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRdData[0] && ctlWrEn && ctlWrData[0]) |=> !measStart);

  // R4: completion flag never seen without the running flag
  p_done_needs_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdData[1] |-> ctlRdData[0]);

  // R10: valid lasts one cycle and follows a cycle with completion set
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  p_valid_after_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(ctlRdData[1]));

  // R10: verdict holds except on a launch or a new verdict
  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!resultValid && !measStart) |-> $stable(resultCode));

  // R11: stop write clears both flags
  p_stop_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && !ctlWrData[0]) |=> (ctlRdData == 2'b00));

  // R9: classifier never produces the reserved code
  p_code_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultCode != 2'd3);

endmodule

bind cable_diag_classifier cdiag_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctlWrEn    (ctlWrEn),
  .ctlWrData  (ctlWrData),
  .ctlRdData  (ctlRdData),
  .measStart  (measStart),
  .resultValid(resultValid),
  .resultCode (resultCode)
);

// File: tb/tb_cable_diag_classifier.sv
module tb_cable_diag_classifier;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [1:0]  ctlWrData = 2'b00;
  logic [1:0]  ctlRdData;
  logic        measStart;
  logic        measDone = 1'b0;
  logic [11:0] posAmp = '0;
  logic [11:0] negAmp = '0;
  logic [7:0]  gainIdx = '0;
  logic [13:0] posTime = '0;
  logic [13:0] negTime = '0;
  logic        resultValid;
  logic [1:0]  resultCode;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  cable_diag_classifier dut (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .measStart(measStart), .measDone(measDone),
    .posAmp(posAmp), .negAmp(negAmp), .gainIdx(gainIdx),
    .posTime(posTime), .negTime(negTime),
    .resultValid(resultValid), .resultCode(resultCode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5: phases = cycle field * 96 + phase field
  function automatic int phasesOf(input int word);
    return ((word >> 7) & 127) * 96 + (word & 127);
  endfunction

  // R6..R9 reference verdict
  function automatic int refCode(input int pa, input int na, input int pt,
                                 input int nt, input int g);
    int pp, np, raw;
    pp = phasesOf(pt);
    np = phasesOf(nt);
    raw = 0;
    if (pp - np >= 96 && pp - np < 185 && pp > 0 && 0 < np + 30) raw = 2;
    else if (np - pp >= 96 && np - pp < 185 && np > 0 && 0 < pp + 30) raw = 1;
    if (!(pa > 20 && na > 20 && g >= 0)) raw = 0;
    return raw;
  endfunction

  function automatic int pack(input int ph);
    return ((ph / 96) << 7) | (ph % 96);
  endfunction

  task automatic ctlWrite(input logic [1:0] d);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = d;
    @(negedge clk);
    ctlWrEn = 1'b0; ctlWrData = 2'b00;
  endtask

  // one full measurement: launch, complete, check verdict, stop
  task automatic runMeas(input int pa, input int na, input int pt,
                         input int nt, input int g, input string tag);
    int exp;
    exp = refCode(pa, na, pt, nt, g);
    ctlWrite(2'b01);
    check({"R2 launch pulse ", tag}, int'(measStart), 1);
    check({"R10 code cleared on launch ", tag}, int'(resultCode), 0);
    posAmp = 12'(pa); negAmp = 12'(na); posTime = 14'(pt); negTime = 14'(nt);
    gainIdx = 8'(g);
    measDone = 1'b1;
    @(negedge clk);
    measDone = 1'b0;
    check({"R4 completion flag ", tag}, int'(ctlRdData), 3);
    check({"R10 no early valid ", tag}, int'(resultValid), 0);
    @(negedge clk);
    check({"R10 valid pulse ", tag}, int'(resultValid), 1);
    check({"R6-verdict ", tag}, int'(resultCode), exp);
    @(negedge clk);
    check({"R10 valid one cycle ", tag}, int'(resultValid), 0);
    ctlWrite(2'b00);
    check({"R11 stop clears flags ", tag}, int'(ctlRdData), 0);
    check({"R11 code held after stop ", tag}, int'(resultCode), exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all R actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_c0de;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctl reset", int'(ctlRdData), 0);
    check("R1 valid reset", int'(resultValid), 0);
    check("R1 code reset", int'(resultCode), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: done while idle ignored
    measDone = 1'b1;
    @(negedge clk);
    measDone = 1'b0;
    check("R4 idle done ignored ctl", int'(ctlRdData), 0);
    @(negedge clk);
    check("R4 idle done no valid", int'(resultValid), 0);

    // R7 open, R8 short
    runMeas(40, 40, pack(300), pack(400), 5, "R7 open");
    runMeas(40, 40, pack(500), pack(400), 5, "R8 short");
    // R6 window boundaries
    runMeas(40, 40, pack(595), pack(500), 0, "R6 sep 95");
    runMeas(40, 40, pack(596), pack(500), 0, "R6 sep 96");
    runMeas(40, 40, pack(684), pack(500), 0, "R6 sep 184");
    runMeas(40, 40, pack(685), pack(500), 0, "R6 sep 185");
    runMeas(40, 40, pack(500), pack(596), 0, "R6 neg sep 96");
    runMeas(40, 40, pack(500), pack(685), 0, "R6 neg sep 185");
    runMeas(40, 40, pack(500), pack(500), 0, "R6 equal");
    // R9 noise gate and gain sign
    runMeas(20, 40, pack(500), pack(400), 0, "R9 amp 20");
    runMeas(21, 21, pack(500), pack(400), 0, "R9 amp 21");
    runMeas(40, 20, pack(300), pack(400), 0, "R9 neg amp 20");
    runMeas(40, 40, pack(500), pack(400), -1, "R9 gain -1");
    // R5 phase field above 95: 3*96+10=298 vs 1*96+100=196, sep 102
    runMeas(40, 40, (3 << 7) | 10, (1 << 7) | 100, 1, "R5 wide phase");
    check("R5 wide phase short", int'(resultCode), 2);

    // R3: start while running ignored; R11: stop before verdict
    ctlWrite(2'b01);
    @(negedge clk);
    ctlWrite(2'b01);
    check("R3 no second pulse", int'(measStart), 0);
    check("R3 ctl unchanged", int'(ctlRdData), 1);
    ctlWrite(2'b00);
    measDone = 1'b1;
    @(negedge clk);
    measDone = 1'b0;
    check("R11 abort ctl idle", int'(ctlRdData), 0);
    @(negedge clk);
    check("R11 abort no valid", int'(resultValid), 0);

    // R3: start while completion set is ignored, code held
    runMeas(40, 40, pack(300), pack(400), 5, "R3 prep");
    ctlWrite(2'b01);
    posAmp = 12'd40; negAmp = 12'd40; posTime = 14'(pack(500)); negTime = 14'(pack(400));
    measDone = 1'b1;
    @(negedge clk);
    measDone = 1'b0;
    @(negedge clk);
    ctlWrite(2'b01);
    check("R3 ignored in done no pulse", int'(measStart), 0);
    check("R3 ignored in done ctl", int'(ctlRdData), 3);
    check("R3 ignored in done code", int'(resultCode), 2);
    ctlWrite(2'b00);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int np, off, pp, pa, na, g;
      np  = 200 + int'($urandom_range(0, 5000));
      off = int'($urandom_range(0, 440)) - 220;
      pp  = np + off;
      pa  = int'($urandom_range(0, 60));
      na  = int'($urandom_range(0, 60));
      g   = int'($urandom_range(0, 24)) - 4;
      runMeas(pa, na, pack(pp), pack(np), g, "R6 R7 R8 R9 random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule